// File: doc/BRIEF.md
# Eight-Input Interrupt Controller with Command-Word Initialization

This block collects eight interrupt request lines, latches or samples them according to a per-line trigger select, and reports the most urgent unmasked request as an interrupt output plus an 8-bit vector. Software talks to it through a byte-wide port with one address bit, a write strobe and a read strobe. A trigger-select strobe picks the trigger register instead of the command port.

Before the block raises any interrupt it must be initialized. An even-address write with data bit 4 set opens a sequence. The following odd-address writes are read in turn as the vector base, then the cascade configuration, then the mode word. The first word says whether the cascade word and the mode word are present. Once the sequence ends, odd-address writes load the mask. Opening the sequence resets the mask and the cascade setting, so the block can be restarted at any time.

A one-cycle acknowledge input takes the place of a bus acknowledge cycle. It retires the request that is currently selected.

Top module: `intc8`

## Requirements
- R1: After reset, `ready`, `int_out` and `cfg_upm` are 0, `vector` is 0x00, `cfg_cascade` is 0x07, and the mask and trigger registers read 0x00.
- R2: A command write (`wr`=1, `sel_trig`=0) to address 0 with `wdata[4]`=1 starts a new sequence from any state. It clears the mask to 0x00, sets `cfg_cascade` to 0x07, clears `cfg_upm` and drops `ready`. Its bit 1 is the single flag and its bit 0 is the mode-word flag.
- R3: A command write to address 0 with `wdata[4]`=0 changes neither the mask, nor `ready`, nor the sequence position.
- R4: The first address-1 write after the start word loads `wdata[7:3]` as the vector base. `wdata[2:0]` of that write is ignored.
- R5: With the single flag at 0, the next address-1 write loads `cfg_cascade` in full. With the single flag at 1, that step is skipped and `cfg_cascade` stays 0x07.
- R6: With the mode-word flag at 1, the next address-1 write sets `cfg_upm` from `wdata[0]`. With the flag at 0, no mode word is taken and `cfg_upm` stays 0. `ready` rises after the last expected word.
- R7: While `ready`=1, an address-1 command write loads the mask, where a 1 masks that input. Address-1 writes taken as sequence words never change the mask.
- R8: A write with `sel_trig`=1 loads the trigger register, where 1 means level-triggered and 0 means edge-triggered. A read with `sel_trig`=1 returns it unchanged.
- R9: An edge-triggered input latches a request on a 0-to-1 transition and keeps it after the line falls. A level-triggered input requests only while the line is high.
- R10: `int_out` is 1 exactly when `ready`=1 and some unmasked request is pending. `vector` is the base in bits [7:3], with bits [2:0] holding the lowest-numbered such input (input 0 has the highest priority).
- R11: An `ack` pulse while `int_out`=1 clears the latched request of the selected input. A level input that is still high keeps requesting.
- R12: A `rd` pulse returns data on `rdata` one cycle later. With `sel_trig`=0, address 1 gives the mask and address 0 gives the pending request bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 1 | Port address bit |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| sel_trig | input | 1 | Selects the trigger register for the access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Request lines |
| ack | input | 1 | Acknowledge pulse for the selected request |
| int_out | output | 1 | Interrupt output |
| vector | output | 8 | Base and selected input number |
| ready | output | 1 | Initialization complete |
| cfg_cascade | output | 8 | Cascade word (slave bitmap or own ID) |
| cfg_upm | output | 1 | Microprocessor mode bit |

## Verification
The assertions assume at most one of write, read or acknowledge is active in a cycle. They also assume that the request lines are synchronous to `clk` and change only when `ack` is low. The stimulus drives every strobe as a one-cycle pulse on the falling edge. It holds each request pattern for several cycles before it samples or acknowledges, and it never changes the request lines in the cycle of an acknowledge pulse. The random part changes the mask, the trigger select and the request pattern between checks, and it reads back the pending and mask registers after each step.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
    typedef enum logic [2:0] {
        SEQ_OFF = 3'd0,
        SEQ_W2  = 3'd1,
        SEQ_W3  = 3'd2,
        SEQ_W4  = 3'd3,
        SEQ_RDY = 3'd4
    } seq_e;

    localparam int START_BIT  = 4;
    localparam int SINGLE_BIT = 1;
    localparam int MODEW_BIT  = 0;
    localparam int UPM_BIT    = 0;
    localparam logic [7:0] CAS_DEFAULT = 8'h07;
endpackage

// File: rtl/intc8_seq.sv
module intc8_seq
    import intc8_pkg::*;
#(
    parameter int DW   = 8,
    parameter int N_IN = 8,
    localparam int IDXW = $clog2(N_IN),
    localparam int BW   = DW - IDXW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            addr,
    input  logic [DW-1:0]   wdata,
    output logic            ready,
    output logic [N_IN-1:0] mask,
    output logic [BW-1:0]   base,
    output logic [DW-1:0]   cascade,
    output logic            upm
);
    typedef struct packed {
        seq_e            state;
        logic [N_IN-1:0] mask;
        logic [BW-1:0]   base;
        logic [DW-1:0]   cas;
        logic            upm;
        logic            single;
        logic            modew;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (we && !addr && wdata[START_BIT]) begin
            seq_d.state  = SEQ_W2;
            seq_d.mask   = '0;
            seq_d.cas    = CAS_DEFAULT;
            seq_d.upm    = 1'b0;
            seq_d.single = wdata[SINGLE_BIT];
            seq_d.modew  = wdata[MODEW_BIT];
        end else if (we && addr) begin
            case (seq_q.state)
                SEQ_W2: begin
                    seq_d.base = wdata[DW-1:IDXW];
                    if (!seq_q.single)    seq_d.state = SEQ_W3;
                    else if (seq_q.modew) seq_d.state = SEQ_W4;
                    else                  seq_d.state = SEQ_RDY;
                end
                SEQ_W3: begin
                    seq_d.cas   = wdata;
                    seq_d.state = seq_q.modew ? SEQ_W4 : SEQ_RDY;
                end
                SEQ_W4: begin
                    seq_d.upm   = wdata[UPM_BIT];
                    seq_d.state = SEQ_RDY;
                end
                SEQ_RDY: seq_d.mask = wdata[N_IN-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state  <= SEQ_OFF;
            seq_q.mask   <= '0;
            seq_q.base   <= '0;
            seq_q.cas    <= CAS_DEFAULT;
            seq_q.upm    <= 1'b0;
            seq_q.single <= 1'b0;
            seq_q.modew  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready   = (seq_q.state == SEQ_RDY);
    assign mask    = seq_q.mask;
    assign base    = seq_q.base;
    assign cascade = seq_q.cas;
    assign upm     = seq_q.upm;
endmodule

// File: rtl/intc8_req.sv
module intc8_req #(
    parameter int N_IN = 8,
    localparam int IDXW = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] irq_in,
    input  logic            trig_we,
    input  logic [N_IN-1:0] trig_wd,
    input  logic            clr_valid,
    input  logic [IDXW-1:0] clr_idx,
    output logic [N_IN-1:0] trig,
    output logic [N_IN-1:0] pend
);
    typedef struct packed {
        logic [N_IN-1:0] sync;
        logic [N_IN-1:0] prev;
        logic [N_IN-1:0] latch;
        logic [N_IN-1:0] trig;
    } req_s;

    req_s req_d, req_q;
    logic [N_IN-1:0] rise, clr;

    always_comb begin
        rise  = req_q.sync & ~req_q.prev;
        clr   = clr_valid ? (N_IN'(1) << clr_idx) : '0;
        req_d = req_q;
        req_d.sync  = irq_in;
        req_d.prev  = req_q.sync;
        req_d.latch = (req_q.latch & ~clr) | (rise & ~req_q.trig);
        if (trig_we) req_d.trig = trig_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign trig = req_q.trig;
    assign pend = req_q.latch | (req_q.sync & req_q.trig);
endmodule

// File: rtl/intc8_prio.sv
module intc8_prio #(
    parameter int N_IN = 8,
    localparam int IDXW = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] req,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/intc8.sv
module intc8
    import intc8_pkg::*;
#(
    parameter int DW   = 8,
    parameter int N_IN = 8,
    localparam int IDXW = $clog2(N_IN),
    localparam int BW   = DW - IDXW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr,
    input  logic            wr,
    input  logic            rd,
    input  logic            sel_trig,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [N_IN-1:0] irq_in,
    input  logic            ack,
    output logic            int_out,
    output logic [DW-1:0]   vector,
    output logic            ready,
    output logic [DW-1:0]   cfg_cascade,
    output logic            cfg_upm
);
    logic [N_IN-1:0] mask_w, trig_w, pend_w;
    logic [BW-1:0]   base_w;
    logic            any_w;
    logic [IDXW-1:0] idx_w;
    logic [DW-1:0]   rdata_d, rdata_q;

    intc8_seq #(.DW(DW), .N_IN(N_IN)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr && !sel_trig),
        .addr    (addr),
        .wdata   (wdata),
        .ready   (ready),
        .mask    (mask_w),
        .base    (base_w),
        .cascade (cfg_cascade),
        .upm     (cfg_upm)
    );

    intc8_req #(.N_IN(N_IN)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .trig_we   (wr && sel_trig),
        .trig_wd   (wdata[N_IN-1:0]),
        .clr_valid (ack && int_out),
        .clr_idx   (idx_w),
        .trig      (trig_w),
        .pend      (pend_w)
    );

    intc8_prio #(.N_IN(N_IN)) u_prio (
        .req (pend_w & ~mask_w),
        .any (any_w),
        .idx (idx_w)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd) begin
            if (sel_trig)  rdata_d = trig_w;
            else if (addr) rdata_d = mask_w;
            else           rdata_d = pend_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata   = rdata_q;
    assign int_out = ready && any_w;
    assign vector  = {base_w, idx_w};
endmodule

// File: rtl/intc8_chk.sv
module intc8_chk #(
    parameter int DW   = 8,
    parameter int N_IN = 8,
    localparam int IDXW = $clog2(N_IN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr,
    input logic            addr,
    input logic            sel_trig,
    input logic [DW-1:0]   wdata,
    input logic            ready,
    input logic [N_IN-1:0] mask,
    input logic [N_IN-1:0] trig,
    input logic [N_IN-1:0] pend,
    input logic            int_out,
    input logic [DW-1:0]   vector
);
    logic start_w, ocw_w;
    logic [N_IN-1:0] live, below;
    assign start_w = wr && !sel_trig && !addr && wdata[4];
    assign ocw_w   = wr && !sel_trig && !addr && !wdata[4];
    assign live    = pend & ~mask;
    assign below   = (N_IN'(1) << vector[IDXW-1:0]) - N_IN'(1);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (mask == '0 && !ready));

    a_r3_ocw_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        ocw_w |=> ($stable(mask) && $stable(ready)));

    a_r7_mask_held_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !start_w) |=> $stable(mask));

    a_r8_trig_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel_trig) |=> (trig == $past(wdata[N_IN-1:0])));

    a_r10_int_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ready);

    a_r10_vector_winner: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (live[vector[IDXW-1:0]] && ((live & below) == '0)));
endmodule

bind intc8 intc8_chk #(.DW(DW), .N_IN(N_IN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .addr     (addr),
    .sel_trig (sel_trig),
    .wdata    (wdata),
    .ready    (ready),
    .mask     (mask_w),
    .trig     (trig_w),
    .pend     (pend_w),
    .int_out  (int_out),
    .vector   (vector)
);

// File: tb/sim_intc8.sv
module sim_intc8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0, wr = 1'b0, rd = 1'b0, sel_trig = 1'b0, ack = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] irq_in = 8'h00;
    logic [7:0] rdata, vector, cfg_cascade;
    logic       int_out, ready, cfg_upm;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_latch = 8'h00, m_irq = 8'h00, m_trig = 8'h00, m_mask = 8'h00;
    logic [4:0] m_base = 5'h00;

    always #5 clk = ~clk;

    intc8 u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd),
        .sel_trig(sel_trig), .wdata(wdata), .rdata(rdata), .irq_in(irq_in),
        .ack(ack), .int_out(int_out), .vector(vector), .ready(ready),
        .cfg_cascade(cfg_cascade), .cfg_upm(cfg_upm)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic st, input logic [7:0] d);
        @(negedge clk);
        addr = a; sel_trig = st; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic a, input logic st, output logic [7:0] d);
        @(negedge clk);
        addr = a; sel_trig = st; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] f_pend();
        return m_latch | (m_irq & m_trig);
    endfunction

    function automatic logic [2:0] f_idx(input logic [7:0] v);
        logic [2:0] r = 3'd0;
        for (int i = 7; i >= 0; i--) if (v[i]) r = 3'(i);
        return r;
    endfunction

    task automatic drive_irq(input logic [7:0] v);
        @(negedge clk);
        m_latch = m_latch | (v & ~m_irq & ~m_trig);
        m_irq = v;
        irq_in = v;
        settle(3);
    endtask

    task automatic pulse_ack();
        logic [7:0] live;
        live = f_pend() & ~m_mask;
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        if (live != 8'h00) m_latch[f_idx(live)] = 1'b0;
    endtask

    task automatic check_out(input string tag);
        logic [7:0] live, rv;
        live = f_pend() & ~m_mask;
        chk({tag, " int_out"}, int_out, live != 8'h00);
        if (live != 8'h00) chk({tag, " vector"}, vector, {m_base, f_idx(live)});
        bus_rd(1'b0, 1'b0, rv);
        chk({tag, " R12 pend read"}, rv, f_pend());
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL R0 watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        void'($urandom(32'd2718));
        settle(3);
        // R1 reset state
        chk("R1 ready", ready, 0);
        chk("R1 int_out", int_out, 0);
        chk("R1 vector", vector, 8'h00);
        chk("R1 cascade", cfg_cascade, 8'h07);
        chk("R1 upm", cfg_upm, 0);
        rst_n = 1'b1;
        settle(2);
        bus_rd(1'b1, 1'b0, rv); chk("R1 mask", rv, 8'h00);
        bus_rd(1'b0, 1'b1, rv); chk("R1 trig", rv, 8'h00);

        // full sequence: cascade word and mode word present
        bus_wr(1'b0, 1'b0, 8'h11);
        chk("R2 not ready after start", ready, 0);
        bus_wr(1'b1, 1'b0, 8'h2D);
        chk("R4 still in sequence", ready, 0);
        bus_wr(1'b1, 1'b0, 8'h02);
        chk("R5 cascade loaded", cfg_cascade, 8'h02);
        bus_rd(1'b1, 1'b0, rv); chk("R7 mask untouched by sequence", rv, 8'h00);
        bus_wr(1'b1, 1'b0, 8'h01);
        chk("R6 upm set", cfg_upm, 1);
        chk("R6 ready", ready, 1);
        m_base = 5'h05;

        // R7 mask load and read back
        bus_wr(1'b1, 1'b0, 8'hF0);
        bus_rd(1'b1, 1'b0, rv); chk("R7 mask read", rv, 8'hF0);

        // R3 command word with bit 4 clear
        bus_wr(1'b0, 1'b0, 8'h0A);
        bus_rd(1'b1, 1'b0, rv); chk("R3 mask kept", rv, 8'hF0);
        chk("R3 ready kept", ready, 1);

        // R2 restart: single, mode word present, cascade skipped
        bus_wr(1'b0, 1'b0, 8'h13);
        chk("R2 ready dropped", ready, 0);
        chk("R2 cascade reset", cfg_cascade, 8'h07);
        chk("R2 upm cleared", cfg_upm, 0);
        bus_rd(1'b1, 1'b0, rv); chk("R2 mask cleared", rv, 8'h00);
        bus_wr(1'b1, 1'b0, 8'h47);
        bus_wr(1'b1, 1'b0, 8'hAA);
        chk("R6 mode word bit0 0", cfg_upm, 0);
        chk("R5 skipped cascade", cfg_cascade, 8'h07);
        chk("R6 ready after mode word", ready, 1);
        bus_rd(1'b1, 1'b0, rv); chk("R7 mode word not a mask", rv, 8'h00);

        // single, no mode word: ready straight after base
        bus_wr(1'b0, 1'b0, 8'h12);
        bus_wr(1'b1, 1'b0, 8'h20);
        chk("R6 ready without mode word", ready, 1);
        chk("R6 upm stays 0", cfg_upm, 0);
        m_base = 5'h04;
        m_mask = 8'h00;

        // R8 trigger register
        bus_wr(1'b0, 1'b1, 8'hC3);
        bus_rd(1'b0, 1'b1, rv); chk("R8 trig readback", rv, 8'hC3);
        bus_wr(1'b0, 1'b1, 8'h80);
        m_trig = 8'h80;

        // R9 edge input latched after the line falls
        drive_irq(8'h08);
        drive_irq(8'h00);
        check_out("R9 edge latched");
        pulse_ack();
        settle(1);
        check_out("R11 edge cleared");

        // R9 level input follows the line, R11 ack cannot retire it
        drive_irq(8'h80);
        check_out("R9 level high");
        chk("R10 vector level", vector, 8'h27);
        pulse_ack();
        settle(1);
        check_out("R11 level persists");
        drive_irq(8'h00);
        check_out("R9 level low");

        // R10 masked input and priority
        bus_wr(1'b1, 1'b0, 8'h01); m_mask = 8'h01;
        drive_irq(8'h21);
        check_out("R10 masked input0");
        chk("R10 vector input5", vector, 8'h25);
        bus_wr(1'b1, 1'b0, 8'h00); m_mask = 8'h00;
        settle(1);
        check_out("R10 unmasked input0");
        pulse_ack(); pulse_ack();
        drive_irq(8'h00);
        check_out("R11 both cleared");

        // random phase
        for (int it = 0; it < 300; it++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel == 0) begin
                m_mask = 8'($urandom());
                bus_wr(1'b1, 1'b0, m_mask);
                bus_rd(1'b1, 1'b0, rv); chk("R7 random mask read", rv, m_mask);
            end else if (sel == 1) begin
                m_trig = 8'($urandom());
                bus_wr(1'b0, 1'b1, m_trig);
                bus_rd(1'b0, 1'b1, rv); chk("R8 random trig read", rv, m_trig);
            end else if (sel <= 4) begin
                pulse_ack();
                settle(1);
            end else begin
                drive_irq(8'($urandom()));
            end
            check_out("R10 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule